// File: doc/BRIEF.md
# Multiplexed ADC Averaging Sequencer

This block drives a shared successive-approximation converter across five multiplexed voltage channels. There are four external supply inputs and the device's own supply. For each channel it selects the input, issues 16 conversions one after another, and sums the 10-bit results in a 14-bit accumulator. It then writes the rounded-down average into that channel's 8-bit reading register. A one-cycle strobe that carries the channel index tells a downstream limit checker that a fresh value is in place. The analog converter, attenuators and filters sit outside the block. One conversion takes roughly 711 µs, so a full channel dwell takes roughly 11.38 ms.

Channels are visited in the order of their register addresses and the sequence wraps while the enable is held high. The reading registers are presented on a simple combinational read port at byte addresses 0x20 to 0x24. A nominal input of code 768 (three-quarters of full scale) reads back as 0xC0. Dropping the enable lets the conversion in flight complete, discards the partial sum, and parks the sequencer. When the enable returns, the sequencer starts again from the first channel.

Top module: `adc_avg_seq`

## Requirements
- R1: After a synchronous active-low reset, every reading register reads 0x00, `result_valid` is 0, and `conv_start` stays 0 while `enable` is low.
- R2: `mux_sel` carries the channel index 0 to 4, with index i belonging to register address 0x20+i. It steps 0,1,2,3,4 and then wraps to 0. It changes only on the clock edge that samples `conv_done`.
- R3: Each conversion is requested by a `conv_start` pulse exactly one cycle long. No new `conv_start` is issued until `conv_done` has been seen for the previous request.
- R4: The value written for a channel is bits [13:6] of the sum of its 16 consecutive conversion codes. This is the 10-bit average (sum shifted right by 4) with its two low bits dropped. A constant 768 gives 0xC0, a constant 1023 gives 0xFF, and a constant 0 gives 0x00.
- R5: `result_valid` is high for exactly one cycle after each completed 16-conversion dwell. `result_ch` holds the index of the channel just written. No strobe occurs without a completed dwell.
- R6: `rd_data` returns register i when `rd_addr` is 0x20+i. In the strobe cycle it already shows the whole new value, and in every earlier cycle it shows the whole previous value.
- R7: Any `rd_addr` outside 0x20 to 0x24 returns 0x00.
- R8: When `enable` is low at the cycle `conv_done` arrives, the sequencer updates no register, raises no strobe, and issues no further `conv_start` until `enable` rises again.
- R9: After such a park, raising `enable` restarts at channel 0 with an empty accumulator, so the first result after the restart averages 16 fresh conversions.
- R10: If the 16th conversion of a dwell completes while `enable` is low, that dwell is also discarded, and the register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the channel sequence while high |
| mux_sel | output | 3 | Analog multiplexer channel index |
| conv_start | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | Converter result valid, one cycle |
| conv_data | input | 10 | Converter result code |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| result_valid | output | 1 | New averaged result strobe |
| result_ch | output | 3 | Channel index belonging to the strobe |

## Verification
A host read of a reading register can fall in the very cycle in which the sequencer rewrites that register. The bench holds the read address on each channel register in rotation on every cycle. On each strobe it moves the read address to the freshly written channel in that same cycle. A scoreboard keeps the last confirmed value of each register and compares it against `rd_data` on every cycle. This shows that before the strobe a register yields only its whole previous value, and that in the strobe cycle it yields only its whole new value. Separately, the enable is dropped while the 8th and while the 16th conversion of a dwell are in flight, so that a discard falls on the same edge as an arriving result.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and helpers for the ADC averaging sequencer.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package adc_seq_pkg;

    // Sequencer phases: idle, issue a request, wait for the converter.
    typedef enum logic [1:0] {
        SEQ_PARK   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2
    } seq_state_e;

    // Next channel index with wrap from the last back to zero.
    function automatic int unsigned wrap_next(input int unsigned cur,
                                              input int unsigned count);
        return (cur + 1 >= count) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
// Module: channel/sample sequencer FSM.
// Walks the channel index, issues one conversion request per LAUNCH
// cycle and classifies each returning result as taken, last-of-dwell
// or aborted (enable low). Assumes conv_done is a one-cycle pulse that
// only follows a request.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int AVG_LOG2 = 4,
    parameter int CH_W     = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] ch_idx,
    output logic            sample_take,
    output logic            dwell_last,
    output logic            dwell_abort
);

    localparam logic [AVG_LOG2-1:0] LAST_SAMPLE = '1;

    seq_state_e          state_q;
    logic [AVG_LOG2-1:0] cnt_q;
    logic                in_wait;

    // Decode the phase into the request pulse and result classes.
    always_comb begin
        conv_start  = (state_q == SEQ_LAUNCH);
        in_wait     = (state_q == SEQ_WAIT);
        sample_take = in_wait && conv_done && enable;
        dwell_last  = sample_take && (cnt_q == LAST_SAMPLE);
        dwell_abort = in_wait && conv_done && !enable;
    end

    // Phase, sample counter and channel index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_PARK;
            cnt_q   <= '0;
            ch_idx  <= '0;
        end else begin
            case (state_q)
                SEQ_PARK: begin
                    if (enable) state_q <= SEQ_LAUNCH;
                end
                SEQ_LAUNCH: begin
                    state_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (conv_done) begin
                        if (enable) begin
                            state_q <= SEQ_LAUNCH;
                            cnt_q   <= cnt_q + 1'b1;
                            if (cnt_q == LAST_SAMPLE)
                                ch_idx <= CH_W'(wrap_next(int'(ch_idx), NUM_CH));
                        end else begin
                            state_q <= SEQ_PARK;
                            cnt_q   <= '0;
                            ch_idx  <= '0;
                        end
                    end
                end
                default: state_q <= SEQ_PARK;
            endcase
        end
    end

endmodule

// File: rtl/adc_avg_accum.sv
// Module: conversion accumulator and averager.
// Sums 2**AVG_LOG2 codes and presents the top REG_W bits of the
// average of the running sum including the current code. Assumes
// REG_W <= ADC_W. Clears on a completed or aborted dwell.
module adc_avg_accum #(
    parameter int ADC_W    = 10,
    parameter int AVG_LOG2 = 4,
    parameter int REG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_take,
    input  logic             dwell_last,
    input  logic             dwell_abort,
    input  logic [ADC_W-1:0] conv_data,
    output logic [REG_W-1:0] avg_reading
);

    localparam int ACC_W = ADC_W + AVG_LOG2;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    // Running sum including the code now arriving; upper bits form the reading.
    always_comb begin
        sum         = acc_q + ACC_W'(conv_data);
        avg_reading = sum[ACC_W-1 -: REG_W];
    end

    // Accumulator register, emptied at the end of each dwell.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (dwell_last || dwell_abort)
            acc_q <= '0;
        else if (sample_take)
            acc_q <= sum;
    end

endmodule

// File: rtl/adc_reading_regs.sv
// Module: reading register file, read port and result strobe.
// One REG_W register per channel, written whole in one edge, read
// combinationally at BASE_ADDR+i; unknown addresses read zero.
module adc_reading_regs #(
    parameter int               NUM_CH    = 5,
    parameter int               REG_W     = 8,
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20,
    parameter int               CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              result_valid,
    output logic [CH_W-1:0]   result_ch
);

    logic [REG_W-1:0]  reg_q [NUM_CH];
    logic [ADDR_W-1:0] offset;
    logic              in_window;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_reg
            // Channel register: whole value replaced on its write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    reg_q[gi] <= '0;
                else if (wr_en && (wr_idx == CH_W'(gi)))
                    reg_q[gi] <= wr_data;
            end
        end
    endgenerate

    // Address decode and read multiplexer.
    always_comb begin
        offset    = rd_addr - BASE_ADDR;
        in_window = (rd_addr >= BASE_ADDR) && (offset < ADDR_W'(NUM_CH));
        rd_data   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (in_window && (offset == ADDR_W'(i)))
                rd_data = reg_q[i];
        end
    end

    // Strobe and channel tag, aligned with the register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
            result_ch    <= '0;
        end else begin
            result_valid <= wr_en;
            if (wr_en) result_ch <= wr_idx;
        end
    end

endmodule

// File: rtl/adc_avg_seq.sv
// Module: multiplexed ADC averaging sequencer, top level.
// Sequences channels, averages 16 conversions each, stores readings
// and strobes new results. Assumes an external converter with a
// start/done handshake and a stable result while conv_done is high.
module adc_avg_seq #(
    parameter int                NUM_CH    = 5,
    parameter int                ADC_W     = 10,
    parameter int                AVG_LOG2  = 4,
    parameter int                REG_W     = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    output logic [$clog2(NUM_CH)-1:0]  mux_sel,
    output logic                       conv_start,
    input  logic                       conv_done,
    input  logic [ADC_W-1:0]           conv_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [REG_W-1:0]           rd_data,
    output logic                       result_valid,
    output logic [$clog2(NUM_CH)-1:0]  result_ch
);

    localparam int CH_W = $clog2(NUM_CH);

    logic [CH_W-1:0]  ch_idx;
    logic             sample_take;
    logic             dwell_last;
    logic             dwell_abort;
    logic [REG_W-1:0] avg_reading;

    adc_seq_ctrl #(
        .NUM_CH   (NUM_CH),
        .AVG_LOG2 (AVG_LOG2),
        .CH_W     (CH_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .conv_done   (conv_done),
        .conv_start  (conv_start),
        .ch_idx      (ch_idx),
        .sample_take (sample_take),
        .dwell_last  (dwell_last),
        .dwell_abort (dwell_abort)
    );

    adc_avg_accum #(
        .ADC_W    (ADC_W),
        .AVG_LOG2 (AVG_LOG2),
        .REG_W    (REG_W)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_take (sample_take),
        .dwell_last  (dwell_last),
        .dwell_abort (dwell_abort),
        .conv_data   (conv_data),
        .avg_reading (avg_reading)
    );

    adc_reading_regs #(
        .NUM_CH    (NUM_CH),
        .REG_W     (REG_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .CH_W      (CH_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (dwell_last),
        .wr_idx       (ch_idx),
        .wr_data      (avg_reading),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .result_valid (result_valid),
        .result_ch    (result_ch)
    );

    // Multiplexer select follows the sequencer's channel index.
    always_comb mux_sel = ch_idx;

endmodule

// File: rtl/adc_avg_seq_chk.sv
// Module: protocol checker for the averaging sequencer, bound to the top.
// Observes ports only; holds from reset onward.
module adc_avg_seq_chk #(
    parameter int NUM_CH = 5,
    parameter int CH_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic [CH_W-1:0] mux_sel,
    input logic            conv_start,
    input logic            conv_done,
    input logic            result_valid,
    input logic [CH_W-1:0] result_ch
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!result_valid && !conv_start));

    // R2
    mux_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel < CH_W'(NUM_CH));

    // R2
    mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel) |-> $past(conv_done));

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R5
    strobe_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> (result_ch == $past(mux_sel)));

    // R8
    strobe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(enable) && $past(conv_done)));

endmodule

bind adc_avg_seq adc_avg_seq_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .mux_sel      (mux_sel),
    .conv_start   (conv_start),
    .conv_done    (conv_done),
    .result_valid (result_valid),
    .result_ch    (result_ch)
);

// File: tb/adc_avg_seq_bench.sv
// Scoreboard bench: converter stub, reference averaging model feeding a
// queue, monitor comparing strobes and read-port values every cycle.
module adc_avg_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 5;
    localparam int LAT        = 3;

    typedef struct {
        int ch;
        int val;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic [2:0] mux_sel;
    logic       conv_start;
    logic       conv_done;
    logic [9:0] conv_data;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       result_valid;
    logic [2:0] result_ch;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t q[$];
    int   shadow[NCH];
    int   m_ch = 0, m_cnt = 0, m_acc = 0;
    int   pattern = 0;
    int   conv_k = 0;
    int   starts = 0;
    int   strobes = 0;
    int   last_ch = -1, last_val = -1;
    bit   finished = 0;

    adc_avg_seq u_adc_avg_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .mux_sel      (mux_sel),
        .conv_start   (conv_start),
        .conv_done    (conv_done),
        .conv_data    (conv_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .result_valid (result_valid),
        .result_ch    (result_ch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int code_for(input int ch, input int k);
        case (pattern)
            0:       return 768;
            1:       return 1023;
            2:       return 0;
            default: return (ch * 211 + k * 37 + 5) % 1024;
        endcase
    endfunction

    // Driver side of the scoreboard: queue one expected result.
    task automatic push_expected(input int ch, input int sum);
        exp_t e;
        e.ch  = ch;
        e.val = (sum / 16) / 4;
        q.push_back(e);
    endtask

    // Converter stub: answers each request LAT cycles later.
    initial begin
        int lat_cnt = 0;
        conv_done = 1'b0;
        conv_data = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (lat_cnt > 0) begin
                if (conv_start) check(0, "R3", "start while busy", 1, 0);
                lat_cnt--;
                if (lat_cnt == 0) begin
                    conv_data = 10'(code_for(int'(mux_sel), conv_k));
                    conv_k++;
                    conv_done = 1'b1;
                end
            end else if (conv_start && rst_n) begin
                starts++;
                check(int'(mux_sel) == m_ch, "R2", "mux_sel order", int'(mux_sel), m_ch);
                lat_cnt = LAT;
            end
        end
    end

    // Reference model: sampled on the edge where the design takes a result.
    always @(posedge clk) begin
        if (rst_n && conv_done) begin
            if (enable) begin
                m_acc += int'(conv_data);
                m_cnt++;
                if (m_cnt == 16) begin
                    push_expected(m_ch, m_acc);
                    m_acc = 0;
                    m_cnt = 0;
                    m_ch  = (m_ch + 1) % NCH;
                end
            end else begin
                m_acc = 0;
                m_cnt = 0;
                m_ch  = 0;
            end
        end
    end

    // Monitor: pops on each strobe, otherwise sweeps the read port.
    initial begin
        int watch = 0;
        exp_t e;
        rd_addr = 8'h00;
        for (int i = 0; i < NCH; i++) shadow[i] = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (result_valid) begin
                if (q.size() == 0) begin
                    check(0, "R5", "strobe without dwell", int'(result_ch), -1);
                end else begin
                    e = q.pop_front();
                    check(int'(result_ch) == e.ch, "R5", "result_ch", int'(result_ch), e.ch);
                    shadow[e.ch] = e.val;
                    rd_addr = 8'h20 + 8'(e.ch);
                    #1;
                    check(int'(rd_data) == e.val, "R6", "new value at strobe", int'(rd_data), e.val);
                    last_ch  = int'(result_ch);
                    last_val = int'(rd_data);
                    strobes++;
                end
            end else begin
                if (watch < NCH) begin
                    rd_addr = 8'h20 + 8'(watch);
                    #1;
                    check(int'(rd_data) == shadow[watch], (strobes == 0) ? "R1" : "R6",
                          "held register value", int'(rd_data), shadow[watch]);
                end else begin
                    case (watch)
                        NCH:     rd_addr = 8'h25;
                        NCH + 1: rd_addr = 8'h1F;
                        default: rd_addr = 8'hA2;
                    endcase
                    #1;
                    check(rd_data == 8'h00, "R7", "unmapped address", int'(rd_data), 0);
                end
                watch = (watch + 1) % (NCH + 3);
            end
        end
    end

    task automatic wait_strobes(input int n);
        int left = n;
        while (left > 0) begin
            @(negedge clk);
            if (result_valid) left--;
        end
        #2;
    endtask

    task automatic wait_model_count(input int c);
        do @(negedge clk); while (m_cnt != c);
    endtask

    // Watchdog: a hung run is a failed check and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int snap_s, snap_r;
        rst_n  = 1'b0;
        enable = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset with enable low
        repeat (20) begin
            @(negedge clk);
            check(!conv_start && !result_valid, "R1", "quiet while parked",
                  int'(conv_start) + int'(result_valid), 0);
        end

        // R4: nominal code 768 averages to 0xC0
        pattern = 0;
        enable  = 1'b1;
        wait_strobes(NCH);
        check(last_val == 8'hC0, "R4", "nominal reading", last_val, 8'hC0);
        check(last_ch == 4, "R2", "fifth result is last channel", last_ch, 4);

        // R4: full scale 1023 averages to 0xFF
        pattern = 1;
        wait_strobes(NCH);
        check(last_val == 8'hFF, "R4", "full-scale reading", last_val, 8'hFF);

        // R4: zero code averages to 0x00
        pattern = 2;
        wait_strobes(NCH);
        check(last_val == 8'h00, "R4", "zero reading", last_val, 0);

        // R2/R4: varying codes over two wrapped rounds
        pattern = 3;
        wait_strobes(2 * NCH);

        // R8: drop enable with the 8th conversion in flight
        wait_model_count(7);
        enable = 1'b0;
        repeat (20) @(negedge clk);
        snap_s = starts;
        snap_r = strobes;
        repeat (40) @(negedge clk);
        check(starts == snap_s, "R8", "no start while parked", starts - snap_s, 0);
        check(strobes == snap_r, "R8", "no strobe while parked", strobes - snap_r, 0);

        // R9: restart from channel 0 with fresh sums
        enable = 1'b1;
        wait_strobes(1);
        check(last_ch == 0, "R9", "first channel after restart", last_ch, 0);
        wait_strobes(NCH - 1);

        // R10: drop enable while the 16th conversion is in flight
        wait_model_count(15);
        snap_r = strobes;
        enable = 1'b0;
        repeat (40) @(negedge clk);
        check(strobes == snap_r, "R10", "last-sample discard", strobes - snap_r, 0);

        enable = 1'b1;
        wait_strobes(3);
        check(last_ch == 2, "R9", "third channel after restart", last_ch, 2);
        enable = 1'b0;
        repeat (40) @(negedge clk);
        check(q.size() == 0, "R5", "every expected result strobed", q.size(), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule